// File: doc/BRIEF.md
# Byte Mailbox Command Engine

This is a host-side engine that moves data through a one-byte mailbox to a coprocessor. The mailbox offers a byte write strobe, a byte read strobe, a "transmit side empty" flag and a "receive side full" flag. A requester hands the engine one request at a time. The request is a single byte, a 32-bit word, or a register write or read command. The engine turns it into a paced byte sequence, and each byte waits for its own status flag.

Words travel least significant byte first in both directions. Register accesses are framed as a command byte followed by 32-bit words. A receive that waits too long gives up: it contributes a zero byte and flags an error. A guarded single-byte send that waits too long gives up without writing. Both waiting limits are parameters counted in clock cycles.

When a request finishes, the engine pulses `done` for one cycle with the result word and an error bit. It is ready for the next request on the following cycle.

Top module: `mbx_cmd_engine`

## Requirements
- R1: After reset the engine is idle. `req_ready` is 1, and `done`, `mb_wr_en` and `mb_rd_en` are 0.
- R2: Operation 2 (send word) writes the 4 bytes of `req_data` least significant byte first. Operation 0 (send byte) writes `req_data[7:0]` only.
- R3: A byte is written (`mb_wr_en`=1) only in a cycle where `mb_tx_empty` (bit 0 of the output status) is 1. While it is 0, no byte is written.
- R4: A byte is read (`mb_rd_en`=1) only in a cycle where `mb_rx_full` (bit 0 of the input status) is 1. Operation 3 (receive word) assembles the 4 received bytes least significant first into `done_data`.
- R5: Operation 4 (register write) writes byte 0x00, then the 4 bytes of `req_addr`, then the 4 bytes of `req_data`, each word least significant byte first, for 9 bytes in all.
- R6: Operation 5 (register read) writes byte 0x01, then the 4 bytes of `req_addr` least significant first. It then receives one word, which is returned in `done_data`.
- R7: In any receive, a byte whose full flag stays 0 for RX_TMO_CYC cycles is abandoned. That byte becomes 0, `done_err` becomes 1 and the remaining bytes of the word are still attempted.
- R8: In operation 0, if the empty flag stays 0 for TX_TMO_CYC cycles, the engine finishes with no byte written and `done_err`=1.
- R9: Operation 1 (receive byte) returns the byte in `done_data[7:0]`, with bits 31:8 zero.
- R10: Operation codes 6 and 7 are rejected. The engine touches no mailbox strobe, and `done` comes with `done_err`=1 and `done_data`=0.
- R11: `req_ready` is 1 only when idle. `done` is a one-cycle pulse. With the flags always asserted, `done` is visible n clock edges after the accepting edge, where n is the request's total byte count.
- R12: Word sends and register commands (operations 2, 4 and 5) wait on the empty flag without limit. They complete without error after a stall longer than TX_TMO_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and accepting |
| req_op | input | 3 | Operation code (0..5 valid) |
| req_addr | input | 32 | Register address for operations 4 and 5 |
| req_data | input | 32 | Byte or word to send, or register value |
| done | output | 1 | One-cycle completion pulse |
| done_data | output | 32 | Received result (valid with done) |
| done_err | output | 1 | A timeout occurred, or the operation was rejected |
| mb_wr_en | output | 1 | Write strobe for the mailbox data register |
| mb_wr_data | output | 8 | Byte being written |
| mb_rd_en | output | 1 | Read strobe for the mailbox data register |
| mb_rd_data | input | 8 | Byte at the head of the receive side |
| mb_tx_empty | input | 1 | Output status bit 0: transmit side empty |
| mb_rx_full | input | 1 | Input status bit 0: receive side full |

## Verification
When both flags are held asserted, every byte takes one clock edge. `done` therefore appears exactly n edges after the accepting edge, and a rejected code shows `done` straight after acceptance. The bench counts falling edges from the accepting edge to the first `done` and compares that count with the byte total it derives from the operation. A timeout costs exactly the limit in cycles for each abandoned byte, so a receive word with two missing bytes is expected at 2 + 2·RX_TMO_CYC edges and a failed guarded send at TX_TMO_CYC edges. All outputs are sampled at the falling edge, half a period after the register that drives them has settled.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int BYTE_W     = 8;
    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / BYTE_W;
    localparam int SEQ_BYTES  = 1 + 2 * WORD_BYTES;
    localparam int NTX_W      = $clog2(SEQ_BYTES + 1);
    localparam int NRX_W      = $clog2(WORD_BYTES + 1);

    localparam logic [BYTE_W-1:0] CMD_REG_WR = 8'h00;
    localparam logic [BYTE_W-1:0] CMD_REG_RD = 8'h01;

    typedef enum logic [2:0] {
        OP_SEND_BYTE = 3'd0,
        OP_GET_BYTE  = 3'd1,
        OP_SEND_WORD = 3'd2,
        OP_GET_WORD  = 3'd3,
        OP_REG_WR    = 3'd4,
        OP_REG_RD    = 3'd5
    } mbx_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TX,
        ST_RX,
        ST_FIN
    } mbx_state_e;

    typedef struct packed {
        logic [SEQ_BYTES*BYTE_W-1:0] bytes;
        logic [NTX_W-1:0]            ntx;
        logic [NRX_W-1:0]            nrx;
        logic                        guarded;
        logic                        bad;
    } mbx_plan_t;

    // Byte 0 of the outgoing sequence sits in the low byte of 'bytes'.
    function automatic mbx_plan_t make_plan(input logic [2:0] op,
                                            input logic [WORD_W-1:0] addr,
                                            input logic [WORD_W-1:0] data);
        mbx_plan_t p;
        p = '0;
        case (op)
            OP_SEND_BYTE: begin
                p.bytes[BYTE_W-1:0] = data[BYTE_W-1:0];
                p.ntx     = NTX_W'(1);
                p.guarded = 1'b1;
            end
            OP_GET_BYTE:  p.nrx = NRX_W'(1);
            OP_SEND_WORD: begin
                p.bytes[WORD_W-1:0] = data;
                p.ntx = NTX_W'(WORD_BYTES);
            end
            OP_GET_WORD:  p.nrx = NRX_W'(WORD_BYTES);
            OP_REG_WR: begin
                p.bytes = {data, addr, CMD_REG_WR};
                p.ntx   = NTX_W'(SEQ_BYTES);
            end
            OP_REG_RD: begin
                p.bytes[WORD_W+BYTE_W-1:0] = {addr, CMD_REG_RD};
                p.ntx = NTX_W'(1 + WORD_BYTES);
                p.nrx = NRX_W'(WORD_BYTES);
            end
            default: p.bad = 1'b1;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/mbx_wait_timer.sv
module mbx_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (en)    cnt <= cnt + 1'b1;
    end

    // Expires on the limit-th consecutive cycle of waiting.
    assign expire = en && (cnt == limit - 1'b1);
endmodule

// File: rtl/mbx_rx_pack.sv
module mbx_rx_pack #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     put,
    input  logic [BYTE_W-1:0]        din,
    output logic [BYTE_W*NBYTES-1:0] word
);
    localparam int IDX_W = $clog2(NBYTES);

    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            word <= '0;
            idx  <= '0;
        end else if (put) begin
            word[idx*BYTE_W +: BYTE_W] <= din;
            idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/mbx_cmd_engine.sv
module mbx_cmd_engine
    import mbx_pkg::*;
#(
    parameter int unsigned TX_TMO_CYC = 200_000_000,
    parameter int unsigned RX_TMO_CYC = 100_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [WORD_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_data,
    output logic              done,
    output logic [WORD_W-1:0] done_data,
    output logic              done_err,
    output logic              mb_wr_en,
    output logic [BYTE_W-1:0] mb_wr_data,
    output logic              mb_rd_en,
    input  logic [BYTE_W-1:0] mb_rd_data,
    input  logic              mb_tx_empty,
    input  logic              mb_rx_full
);
    localparam int unsigned TMO_MAX = (TX_TMO_CYC > RX_TMO_CYC) ? TX_TMO_CYC : RX_TMO_CYC;
    localparam int CNT_W = $clog2(TMO_MAX + 1);
    localparam logic [CNT_W-1:0] TX_LIM = CNT_W'(TX_TMO_CYC);
    localparam logic [CNT_W-1:0] RX_LIM = CNT_W'(RX_TMO_CYC);

    mbx_state_e                  state;
    logic [SEQ_BYTES*BYTE_W-1:0] txq;
    logic [NTX_W-1:0]            ntx;
    logic [NRX_W-1:0]            nrx;
    logic                        guarded;
    logic                        err;
    mbx_plan_t                   plan;

    logic accept, tx_go, rd_go, tmo_hit, tx_tmo, rx_tmo, rx_step, wait_en;

    assign plan    = make_plan(req_op, req_addr, req_data);
    assign accept  = (state == ST_IDLE) && req_valid;
    assign tx_go   = (state == ST_TX) && mb_tx_empty;
    assign rd_go   = (state == ST_RX) && mb_rx_full;
    assign wait_en = ((state == ST_TX) && !mb_tx_empty) ||
                     ((state == ST_RX) && !mb_rx_full);
    assign tx_tmo  = (state == ST_TX) && guarded && tmo_hit;
    assign rx_tmo  = (state == ST_RX) && tmo_hit;
    assign rx_step = rd_go || rx_tmo;

    mbx_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr    (accept || tx_go || rx_step || tx_tmo),
        .en     (wait_en),
        .limit  ((state == ST_RX) ? RX_LIM : TX_LIM),
        .expire (tmo_hit)
    );

    mbx_rx_pack #(.BYTE_W(BYTE_W), .NBYTES(WORD_BYTES)) u_pack (
        .clk  (clk),
        .rst  (rst),
        .clr  (accept),
        .put  (rx_step),
        .din  (rd_go ? mb_rd_data : '0),
        .word (done_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            txq     <= '0;
            ntx     <= '0;
            nrx     <= '0;
            guarded <= 1'b0;
            err     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    txq     <= plan.bytes;
                    ntx     <= plan.ntx;
                    nrx     <= plan.nrx;
                    guarded <= plan.guarded;
                    err     <= plan.bad;
                    if (plan.bad)           state <= ST_FIN;
                    else if (plan.ntx != 0) state <= ST_TX;
                    else                    state <= ST_RX;
                end
                ST_TX: if (tx_go) begin
                    txq <= txq >> BYTE_W;
                    ntx <= ntx - 1'b1;
                    if (ntx == NTX_W'(1)) state <= (nrx != 0) ? ST_RX : ST_FIN;
                end else if (tx_tmo) begin
                    err   <= 1'b1;
                    state <= ST_FIN;
                end
                ST_RX: if (rx_step) begin
                    if (rx_tmo) err <= 1'b1;
                    nrx <= nrx - 1'b1;
                    if (nrx == NRX_W'(1)) state <= ST_FIN;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready  = (state == ST_IDLE);
    assign done       = (state == ST_FIN);
    assign done_err   = err;
    assign mb_wr_en   = tx_go;
    assign mb_wr_data = txq[BYTE_W-1:0];
    assign mb_rd_en   = rd_go;
endmodule

// File: rtl/mbx_cmd_engine_chk.sv
module mbx_cmd_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic       done,
    input logic       mb_wr_en,
    input logic       mb_rd_en,
    input logic       mb_tx_empty,
    input logic       mb_rx_full
);
    a_r3_write_needs_empty: assert property (@(posedge clk) disable iff (rst)
        mb_wr_en |-> mb_tx_empty);

    a_r4_read_needs_full: assert property (@(posedge clk) disable iff (rst)
        mb_rd_en |-> mb_rx_full);

    a_r11_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    a_r11_idle_port_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !(mb_wr_en || mb_rd_en));

    a_r10_done_not_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !req_ready);
endmodule

bind mbx_cmd_engine mbx_cmd_engine_chk u_chk (.*);

// File: tb/mbx_cmd_engine_tb.sv
module mbx_cmd_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TX_TMO = 8;
    localparam int RX_TMO = 12;
    localparam int NVEC = 8;

    // {op, addr, data, rx word preloaded, expected done_data}
    localparam logic [130:0] VEC [NVEC] = '{
        {3'd0, 32'h0000_0000, 32'h0000_00A5, 32'h0000_0000, 32'h0000_0000},
        {3'd1, 32'h0000_0000, 32'h0000_0000, 32'h0000_003C, 32'h0000_003C},
        {3'd2, 32'h0000_0000, 32'h1122_3344, 32'h0000_0000, 32'h0000_0000},
        {3'd3, 32'h0000_0000, 32'h0000_0000, 32'hCAFE_F00D, 32'hCAFE_F00D},
        {3'd4, 32'h80A0_0000, 32'h0000_0021, 32'h0000_0000, 32'h0000_0000},
        {3'd5, 32'h80E0_0000, 32'h0000_0000, 32'h0000_0001, 32'h0000_0001},
        {3'd6, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0000_0000, 32'h0000_0000},
        {3'd1, 32'h0000_0000, 32'h0000_0000, 32'h0000_00FF, 32'h0000_00FF}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = 3'd0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic        done;
    logic [31:0] done_data;
    logic        done_err;
    logic        mb_wr_en;
    logic [7:0]  mb_wr_data;
    logic        mb_rd_en;
    logic [7:0]  mb_rd_data;
    logic        mb_tx_empty;
    logic        mb_rx_full;

    // Mailbox model
    logic       tx_on = 1'b1;
    logic       q_rst = 1'b1;
    logic [7:0] rxq [4];
    int         rx_tail = 0;
    int         rx_head;
    logic [7:0] wlog [16];
    int         wcnt;

    int checks = 0;
    int errs = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_cmd_engine #(.TX_TMO_CYC(TX_TMO), .RX_TMO_CYC(RX_TMO)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .done(done), .done_data(done_data), .done_err(done_err),
        .mb_wr_en(mb_wr_en), .mb_wr_data(mb_wr_data), .mb_rd_en(mb_rd_en),
        .mb_rd_data(mb_rd_data), .mb_tx_empty(mb_tx_empty), .mb_rx_full(mb_rx_full)
    );

    assign mb_tx_empty = tx_on;
    assign mb_rx_full  = (rx_head < rx_tail);
    assign mb_rd_data  = rxq[rx_head[1:0]];

    always @(posedge clk) begin
        if (q_rst) begin
            rx_head <= 0;
            wcnt    <= 0;
        end else begin
            if (mb_wr_en) begin
                if (wcnt < 16) wlog[wcnt] <= mb_wr_data;
                wcnt <= wcnt + 1;
            end
            if (mb_rd_en) rx_head <= rx_head + 1;
        end
    end

    function automatic int e_ntx(input logic [2:0] op);
        case (op)
            3'd0: return 1;
            3'd2: return 4;
            3'd4: return 9;
            3'd5: return 5;
            default: return 0;
        endcase
    endfunction

    function automatic int e_nrx(input logic [2:0] op);
        case (op)
            3'd1: return 1;
            3'd3, 3'd5: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic logic [7:0] e_byte(input logic [2:0] op, input logic [31:0] a,
                                          input logic [31:0] d, input int i);
        case (op)
            3'd0: return d[7:0];
            3'd2: return d[8*i +: 8];
            3'd4: return (i == 0) ? 8'h00 : (i < 5) ? a[8*(i-1) +: 8] : d[8*(i-5) +: 8];
            3'd5: return (i == 0) ? 8'h01 : a[8*(i-1) +: 8];
            default: return 8'h00;
        endcase
    endfunction

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd0, 3'd2: return "R2";
            3'd1: return "R9";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_model();
        @(negedge clk);
        q_rst = 1'b1;
        @(negedge clk);
        q_rst = 1'b0;
    endtask

    task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] d);
        req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        forever begin
            @(negedge clk);
            if (done || lat > 4000) break;
            lat++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++; checks++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        q_rst = 1'b0;
        // R1: idle state after reset
        chk(req_ready === 1'b1, "R1 ready", {31'b0, req_ready}, 32'd1);
        chk(done === 1'b0 && mb_wr_en === 1'b0 && mb_rd_en === 1'b0, "R1 quiet",
            {29'b0, done, mb_wr_en, mb_rd_en}, 32'd0);

        for (int v = 0; v < NVEC; v++) begin
            logic [2:0]  op;
            logic [31:0] a, d, rw, ex;
            op = VEC[v][130:128]; a = VEC[v][127:96]; d = VEC[v][95:64];
            rw = VEC[v][63:32];   ex = VEC[v][31:0];
            for (int k = 0; k < 4; k++) rxq[k] = rw[8*k +: 8];
            rx_tail = e_nrx(op);
            tx_on = 1'b1;
            clear_model();
            issue(op, a, d);
            wait_done(lat);
            chk(done_data === ex, op_tag(op), done_data, ex);
            chk(done_err === (op > 3'd5), op_tag(op), {31'b0, done_err}, {31'b0, op > 3'd5});
            chk(lat == e_ntx(op) + e_nrx(op), "R11 latency", lat, e_ntx(op) + e_nrx(op));
            @(negedge clk);
            chk(done === 1'b0 && req_ready === 1'b1, "R11 pulse", {30'b0, done, req_ready}, 32'd1);
            chk(wcnt == e_ntx(op), op_tag(op), wcnt, e_ntx(op));
            chk(rx_head == e_nrx(op), op_tag(op), rx_head, e_nrx(op));
            for (int i = 0; i < e_ntx(op); i++)
                chk(wlog[i] === e_byte(op, a, d, i), op_tag(op), wlog[i], e_byte(op, a, d, i));
        end

        // R7: receive word with only two bytes available
        rxq[0] = 8'h5A; rxq[1] = 8'h6B; rx_tail = 2; tx_on = 1'b1;
        clear_model();
        issue(3'd3, '0, '0);
        wait_done(lat);
        chk(done_data === 32'h0000_6B5A, "R7 data", done_data, 32'h0000_6B5A);
        chk(done_err === 1'b1, "R7 err", {31'b0, done_err}, 32'd1);
        chk(lat == 2 + 2 * RX_TMO, "R7 latency", lat, 2 + 2 * RX_TMO);
        chk(rx_head == 2, "R4 no read while empty", rx_head, 2);

        // R7: single byte receive with nothing available
        rx_tail = 0;
        clear_model();
        issue(3'd1, '0, '0);
        wait_done(lat);
        chk(done_data === 32'h0 && done_err === 1'b1, "R7 byte", {done_data[30:0], done_err}, 32'd1);
        chk(lat == RX_TMO, "R7 byte latency", lat, RX_TMO);

        // R8: guarded byte send times out without writing
        tx_on = 1'b0;
        clear_model();
        issue(3'd0, '0, 32'h0000_0077);
        wait_done(lat);
        chk(done_err === 1'b1, "R8 err", {31'b0, done_err}, 32'd1);
        chk(lat == TX_TMO, "R8 latency", lat, TX_TMO);
        @(negedge clk);
        chk(wcnt == 0, "R8 no write", wcnt, 0);

        // R12 and R3: word send stalls past the send limit, then completes
        tx_on = 1'b0;
        clear_model();
        issue(3'd2, '0, 32'hDEAD_BEEF);
        repeat (TX_TMO + 6) @(negedge clk);
        chk(done === 1'b0, "R12 still waiting", {31'b0, done}, 32'd0);
        chk(wcnt == 0, "R3 no write while full", wcnt, 0);
        tx_on = 1'b1;
        wait_done(lat);
        chk(done_err === 1'b0, "R12 err", {31'b0, done_err}, 32'd0);
        @(negedge clk);
        chk(wcnt == 4, "R12 count", wcnt, 4);
        for (int i = 0; i < 4; i++)
            chk(wlog[i] === e_byte(3'd2, '0, 32'hDEAD_BEEF, i), "R12 bytes", wlog[i],
                e_byte(3'd2, '0, 32'hDEAD_BEEF, i));

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule